// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (clock line and data line). Through it, a host can read and write a bank of 8-bit control registers. SCL and SDA arrive as oversampled levels in the block's clock domain. The block drives SDA low through an output enable, so the pad stays open-drain. Every register is also presented in parallel on a flat output bus, where downstream logic reads its settings.

A transfer opens with the device address. The next byte is a command. Its top bit chooses one of two modes. In indexed mode, the low seven bits name one register. In sequential mode, the transfer walks the bank from register 0 upward.

A sequential write normally carries a byte-count byte ahead of its data. A configuration bit inside the bank removes that byte. A sequential read always returns a count byte before the data. Reads use a write phase for the command, then a repeated start with the read address. The bank holds its reset values until the host writes to it, so downstream logic works without any bus traffic.

Top module: `regbus_slave`

## Requirements
- R1: After reset, register i holds 0x40 | i for every index i. sda_oe is low.
- R2: The slave answers only the 7-bit address 0x69 (0xD2 for a write, 0xD3 for a read). A byte with any other address gets no acknowledge, and SDA stays released until the next start condition.
- R3: Indexed write: a command byte with bit 7 = 1 gives the register index in bits 6:0. The next byte is stored in that register. Register i appears on regs_o[8i+7:8i].
- R4: Indexed read: the command goes in a write phase, then a repeated start and 0xD3. The slave then returns one byte, the value of the indexed register, MSB first.
- R5: Sequential write: a command byte with bit 7 = 0 starts at register 0. A count byte follows and is acknowledged, but its value does not limit the transfer. Each later byte lands in the next higher register.
- R6: When bit 7 of register 31 is 1, a sequential write has no count byte. The first byte after the command goes to register 0.
- R7: Sequential read: the first byte returned is 32, the number of registers, whatever the value of the skip bit. Registers 0, 1, 2 and so on follow until the master answers with no acknowledge. SDA is then released.
- R8: A write to an index of 32 or more is acknowledged and discarded. A read of such an index returns 0x00.
- R9: A stop or start condition in the middle of a byte abandons that byte, and no register changes. After a start, the next byte is an address.
- R10: The slave pulls SDA low in the acknowledge slot after a matching address, a command byte, a count byte and each written data byte.
- R11: sda_oe changes only right after a detected falling edge of SCL, or on a start or stop condition. It never changes while SCL is steadily high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREG*8 | All registers side by side, register 0 in the low byte |

## Verification
The hardest cases to reach are the aborts in the middle of a byte. Here a stop or a repeated start arrives after the shift register has taken only part of a data byte, and the slave must drop that byte. The bench drives the bus at bit level, so it can stop after any bit. It then reads the bank back through the parallel outputs and through a later indexed read. The skip bit is reached by writing it over the bus first. A sequential write then runs in which a swallowed first byte would shift every later byte by one register.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } phase_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_CNT,
        RL_DATA
    } role_e;

    // Power-up content of register idx
    function automatic logic [7:0] reg_default(int idx);
        return 8'((idx % 64) | 64);
    endfunction

endpackage

// File: rtl/regbus_sampler.sv
module regbus_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [SYNC-1:0] scl_sh;
        logic [SYNC-1:0] sda_sh;
        logic            scl_p;
        logic            sda_p;
    } samp_t;

    samp_t s_d, s_q;
    logic  scl_s;

    always_comb begin
        s_d        = s_q;
        s_d.scl_sh = {s_q.scl_sh[SYNC-2:0], scl_i};
        s_d.sda_sh = {s_q.sda_sh[SYNC-2:0], sda_i};
        s_d.scl_p  = s_q.scl_sh[SYNC-1];
        s_d.sda_p  = s_q.sda_sh[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_s     = s_q.scl_sh[SYNC-1];
    assign sda_s     = s_q.sda_sh[SYNC-1];
    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign start_det = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/regbus_bank.sv
module regbus_bank #(
    parameter int NREG     = 32,
    parameter int IDX_W    = 5,
    parameter int OFS_W    = 7,
    parameter int SKIP_REG = 31,
    parameter int SKIP_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic              cnt_skip,
    output logic [NREG*8-1:0] regs_o
);
    localparam logic [OFS_W:0] NREG_B = (OFS_W+1)'(NREG);

    logic [NREG-1:0][7:0] r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                r_q[i] <= regbus_pkg::reg_default(i);
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data  = ({1'b0, rd_idx} < NREG_B) ? r_q[rd_idx[IDX_W-1:0]] : 8'h00;
    assign cnt_skip = r_q[SKIP_REG][SKIP_BIT];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*8 +: 8] = r_q[g];
    end

endmodule

// File: rtl/regbus_engine.sv
module regbus_engine
    import regbus_pkg::*;
#(
    parameter int         NREG  = 32,
    parameter int         IDX_W = 5,
    parameter int         OFS_W = 7,
    parameter logic [6:0] ADDR7 = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_s,
    input  logic             cnt_skip,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic [OFS_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    localparam logic [OFS_W:0] NREG_B   = (OFS_W+1)'(NREG);
    localparam logic [7:0]     CNT_BYTE = 8'(NREG);

    typedef struct packed {
        phase_e           phase;
        role_e            role;
        logic [3:0]       bitcnt;
        logic [7:0]       sh;
        logic             blk;
        logic [OFS_W-1:0] ptr;
        logic             go_tx;
        logic             txcnt;
        logic             oe;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d     = e_q;
        wr_en   = 1'b0;
        wr_idx  = e_q.ptr[IDX_W-1:0];
        wr_data = e_q.sh;
        if (stop_det) begin
            e_d.phase = ST_IDLE;
            e_d.oe    = 1'b0;
        end else if (start_det) begin
            e_d.phase  = ST_RX;
            e_d.role   = RL_ADDR;
            e_d.bitcnt = 4'd0;
            e_d.oe     = 1'b0;
        end else begin
            unique case (e_q.phase)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise && e_q.bitcnt < 4'd8) begin
                        e_d.sh     = {e_q.sh[6:0], sda_s};
                        e_d.bitcnt = e_q.bitcnt + 4'd1;
                    end else if (scl_fall && e_q.bitcnt == 4'd8) begin
                        e_d.phase = ST_ACK;
                        e_d.oe    = 1'b1;
                        e_d.go_tx = 1'b0;
                        unique case (e_q.role)
                            RL_ADDR: begin
                                if (e_q.sh[7:1] == ADDR7) begin
                                    if (e_q.sh[0]) begin
                                        e_d.go_tx = 1'b1;
                                        e_d.txcnt = e_q.blk;
                                    end else begin
                                        e_d.role = RL_CMD;
                                    end
                                end else begin
                                    e_d.phase = ST_IDLE;
                                    e_d.oe    = 1'b0;
                                end
                            end
                            RL_CMD: begin
                                e_d.blk  = ~e_q.sh[7];
                                e_d.ptr  = e_q.sh[7] ? e_q.sh[OFS_W-1:0] : '0;
                                e_d.role = (!e_q.sh[7] && !cnt_skip) ? RL_CNT : RL_DATA;
                            end
                            RL_CNT: begin
                                e_d.role = RL_DATA;
                            end
                            RL_DATA: begin
                                wr_en = ({1'b0, e_q.ptr} < NREG_B);
                                if (e_q.ptr != '1) begin
                                    e_d.ptr = e_q.ptr + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        e_d.bitcnt = 4'd0;
                        if (e_q.go_tx) begin
                            e_d.phase = ST_TX;
                            e_d.sh    = e_q.txcnt ? CNT_BYTE : rd_data;
                            e_d.oe    = ~e_d.sh[7];
                        end else begin
                            e_d.phase = ST_RX;
                            e_d.oe    = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (e_q.bitcnt == 4'd7) begin
                            e_d.phase = ST_MACK;
                            e_d.oe    = 1'b0;
                            if (!e_q.txcnt && e_q.ptr != '1) begin
                                e_d.ptr = e_q.ptr + 1'b1;
                            end
                        end else begin
                            e_d.sh     = {e_q.sh[6:0], 1'b0};
                            e_d.bitcnt = e_q.bitcnt + 4'd1;
                            e_d.oe     = ~e_d.sh[7];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            e_d.phase = ST_IDLE;
                        end else begin
                            e_d.phase = ST_ACK;
                            e_d.go_tx = 1'b1;
                            e_d.txcnt = 1'b0;
                        end
                        e_d.oe = 1'b0;
                    end
                end
                default: e_d.phase = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{phase: ST_IDLE, role: RL_ADDR, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign sda_oe = e_q.oe;
    assign rd_idx = e_q.ptr;

endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
    parameter int         NREG         = 32,
    parameter logic [6:0] ADDR7        = 7'h69,
    parameter int         SYNC         = 2,
    parameter int         CNT_SKIP_REG = NREG - 1,
    parameter int         CNT_SKIP_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    localparam int OFS_W = 7;
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             cnt_skip;
    logic [7:0]       rd_data;
    logic [OFS_W-1:0] rd_idx;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    regbus_sampler #(.SYNC(SYNC)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    regbus_engine #(
        .NREG  (NREG),
        .IDX_W (IDX_W),
        .OFS_W (OFS_W),
        .ADDR7 (ADDR7)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .cnt_skip  (cnt_skip),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    regbus_bank #(
        .NREG     (NREG),
        .IDX_W    (IDX_W),
        .OFS_W    (OFS_W),
        .SKIP_REG (CNT_SKIP_REG),
        .SKIP_BIT (CNT_SKIP_BIT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cnt_skip (cnt_skip),
        .regs_o   (regs_o)
    );

endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
    parameter int NREG  = 32,
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [7:0]        wr_data,
    input logic [NREG*8-1:0] regs_o
);
    // R3
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_o[{$past(wr_idx), 3'b000} +: 8] == $past(wr_data));

    // R9
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R5
    wr_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> scl_fall);

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R11
    oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

endmodule

bind regbus_slave regbus_slave_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_o    (regs_o)
);

// File: tb/sim_regbus_slave.sv
module sim_regbus_slave;
    localparam int CLK_P = 10;
    localparam int NREG  = 32;
    localparam int Q     = 6;
    localparam int NVEC  = 6;
    // {index, data} pairs for indexed write then read
    localparam logic [15:0] VEC [NVEC] = '{
        16'h03A5, 16'h00FF, 16'h1E00, 16'h105A, 16'h0781, 16'h013C
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] regs;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    logic [7:0] model [NREG];
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    regbus_slave #(.NREG(NREG)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs)
    );

    // R11 monitor: drive must not change while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) viol++;
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        int bad = -1;
        checks++;
        for (int i = 0; i < NREG; i++) begin
            if (bad < 0 && regs[i*8 +: 8] !== model[i]) bad = i;
        end
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s reg%0d actual=%0h expected=%0h", req, bad,
                     regs[bad*8 +: 8], model[bad]);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait();
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_line;
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic acked);
        logic bit_v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(bit_v);
        acked = ~bit_v;
    endtask

    task automatic rx_byte(output logic [7:0] v, input logic last);
        logic bit_v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(bit_v);
            v[i] = bit_v;
        end
        send_bit(last);
    endtask

    // R10: every byte sent to a selected slave is acknowledged
    task automatic wr_ack(input logic [7:0] b, input string req);
        logic a;
        tx_byte(b, a);
        chk(req, int'(a), 1);
    endtask

    task automatic byte_write(input logic [7:0] idx, input logic [7:0] data);
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h80 | idx, "R10 cmd");
        wr_ack(data, "R10 data");
        bus_stop();
        if (idx < NREG) model[idx] = data;
    endtask

    task automatic byte_read(input logic [7:0] idx, output logic [7:0] v);
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h80 | idx, "R10 cmd");
        bus_start();
        wr_ack(8'hD3, "R2 read addr");
        rx_byte(v, 1'b1);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic a;
        for (int i = 0; i < NREG; i++) model[i] = 8'(8'h40 | i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk_bank("R1 defaults");
        chk("R1 sda released", int'(sda_oe), 0);

        // R3 / R4 vector walk
        for (int k = 0; k < NVEC; k++) begin
            byte_write(VEC[k][15:8], VEC[k][7:0]);
            chk_bank("R3 indexed write");
            byte_read(VEC[k][15:8], v);
            chk("R4 indexed read", int'(v), int'(VEC[k][7:0]));
        end

        // R5 sequential write with count byte
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h00, "R10 cmd");
        wr_ack(8'h01, "R5 count acked");
        wr_ack(8'hA1, "R5 data");
        wr_ack(8'hB2, "R5 data");
        wr_ack(8'hC3, "R5 data");
        bus_stop();
        model[0] = 8'hA1; model[1] = 8'hB2; model[2] = 8'hC3;
        chk_bank("R5 sequential write");

        // R6 set skip bit, then sequential write without count
        byte_write(8'd31, model[31] | 8'h80);
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h00, "R10 cmd");
        wr_ack(8'h11, "R6 data");
        wr_ack(8'h22, "R6 data");
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22;
        chk_bank("R6 count skipped");

        // R7 sequential read
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h00, "R10 cmd");
        bus_start();
        wr_ack(8'hD3, "R7 read addr");
        rx_byte(v, 1'b0);
        chk("R7 count byte", int'(v), NREG);
        for (int i = 0; i < 4; i++) begin
            rx_byte(v, (i == 3));
            chk("R7 data", int'(v), int'(model[i]));
        end
        chk("R7 released after nack", int'(sda_line), 1);
        bus_stop();

        // R8 out of range
        byte_write(8'd40, 8'h77);
        chk_bank("R8 write discarded");
        byte_read(8'd40, v);
        chk("R8 read zero", int'(v), 0);

        // R2 foreign address ignored
        bus_start();
        tx_byte(8'hD4, a);
        chk("R2 no ack foreign addr", int'(a), 0);
        tx_byte(8'h85, a);
        chk("R2 stays released", int'(a), 0);
        tx_byte(8'h99, a);
        bus_stop();
        chk_bank("R2 no write");

        // R9 stop inside a data byte
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h85, "R10 cmd");
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        chk_bank("R9 stop abort");

        // R9 repeated start inside a data byte, then a fresh read
        bus_start();
        wr_ack(8'hD2, "R10 addr");
        wr_ack(8'h85, "R10 cmd");
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_start();
        wr_ack(8'hD2, "R9 new address phase");
        wr_ack(8'h85, "R10 cmd");
        bus_start();
        wr_ack(8'hD3, "R10 addr");
        rx_byte(v, 1'b1);
        bus_stop();
        chk("R9 start abort", int'(v), int'(model[5]));
        chk_bank("R9 bank intact");

        // R11 drive changes only with SCL low
        chk("R11 no change while SCL high", viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule